// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 64 interrupt request inputs and turns them into a single request to a processor. Each input has its own mode word. The mode word sets a priority level from 0 to 7, the active polarity, and whether the input is edge-detected and held, or followed as a level. On every cycle the block finds the highest-priority pending request. It reports that request's level to the processor and places the source number, in vector form, into a vector register that software can read.

Software configures each source by writing its mode word to the address equal to the source number. Software reads the vector register to identify the source. A held edge request is retired by writing the source number to the clear register. The processor side has four signals: a request output, a level output, an acknowledge input that freezes the vector register, and a current-mask input below which no request is raised.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, every mode word is zero, no request is held, and the vector register, `cpuLevel` and `cpuReq` are all zero. A source whose level is 0 never takes part in arbitration, whatever its input does.
- R2: Among pending sources, the one with the larger level wins: level 7 beats every lower level. The outputs show the new winner within three clock cycles of the input change.
- R3: When several pending sources share the top level, the one with the smallest source number wins.
- R4: A source with its active-low bit set treats input 0 as active and input 1 as inactive. Otherwise input 1 is active.
- R5: An edge-mode source holds a request after an inactive-to-active transition of its corrected input, including after the input returns inactive. The request is cleared only by writing `regWrData[9:4]` equal to its number to the clear register at address 0xFF. A clear naming any other source leaves it untouched.
- R6: A level-mode source is not held. Its request is present exactly while its corrected input is active.
- R7: Reading address 0xFE returns the vector on `regRdData[9:0]`, formatted as {source number, 4'b0000}: source 54 gives 0x360. When nothing is pending, the vector is zero.
- R8: `cpuLevel` always shows the winning level, or 0 when nothing is pending. `cpuReq` is high only when that level is strictly greater than `cpuMask`.
- R9: An `cpuAck` pulse freezes the vector register. Arbitration changes do not alter it until software reads address 0xFE with `regRdEn` high, after which it follows the winner again. `cpuLevel` is never frozen.
- R10: When a clear write and a fresh edge for the same source fall in the same cycle, the request stays held.
- R11: The mode word of source n lives at address n. Bits [2:0] hold the level, bit 3 is active-low and bit 4 selects edge mode. Reading that address returns the word on `regRdData[4:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_SRC | Raw interrupt request inputs |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (releases the vector freeze at 0xFE) |
| regAddr | input | 8 | Register address |
| regWrData | input | 10 | Register write data |
| regRdData | output | 10 | Register read data for `regAddr` |
| cpuAck | input | 1 | Processor acknowledge pulse |
| cpuMask | input | 3 | Processor current mask level |
| cpuReq | output | 1 | Interrupt request to the processor |
| cpuLevel | output | 3 | Level of the winning request |

## Verification
Two pairs of events can land on the same cycle. First, a clear write can meet a fresh edge on the same source. The bench provokes this by dropping a held source's input, then raising it again on the very cycle the clear write for that source is driven. It expects the vector to still name the source, and a second clear with the input steady to retire it. Second, while the vector is frozen, a higher-priority edge arrives. The bench expects `cpuLevel` to move to 7 while the read vector keeps the older source, and a vector read to release the new one.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned VEC_W   = 10;
  localparam int unsigned VEC_LSB = 4;
  localparam int unsigned NUM_W   = VEC_W - VEC_LSB;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned MAX_SRC = 1 << NUM_W;

  localparam logic [ADDR_W-1:0] VEC_ADDR = 8'hFE;
  localparam logic [ADDR_W-1:0] CLR_ADDR = 8'hFF;

  // Per-source mode word, bit 4 edge, bit 3 active-low, bits 2:0 level
  typedef struct packed {
    logic             edgeMode;
    logic             activeLow;
    logic [LVL_W-1:0] lvl;
  } srcMode_t;

  localparam int unsigned MODE_W = $bits(srcMode_t);

  // Strobes from control to datapath
  typedef struct packed {
    logic modeWr;
    logic clrWr;
    logic vecHold;
  } ctrlStrb_t;
endpackage

// File: rtl/pvic_ctrl.sv
module pvic_ctrl
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              cpuAck,
  output ctrlStrb_t         strb,
  output logic              frozen
);
  logic vecRead;
  logic frozenQ;

  assign vecRead = regRdEn && (regAddr == VEC_ADDR);

  // Acknowledge takes precedence over a release in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)        frozenQ <= 1'b0;
    else if (cpuAck)  frozenQ <= 1'b1;
    else if (vecRead) frozenQ <= 1'b0;
  end

  always_comb begin
    strb.modeWr  = regWrEn && (int'(regAddr) < int'(NUM_SRC));
    strb.clrWr   = regWrEn && (regAddr == CLR_ADDR);
    strb.vecHold = cpuAck || frozenQ;
  end

  assign frozen = frozenQ;
endmodule

// File: rtl/pvic_srcdet.sv
module pvic_srcdet
  import pvic_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rawIn,
  input  srcMode_t mode,
  input  logic     clrHit,
  output logic     reqOut
);
  logic corrIn;
  logic prevQ;
  logic pendQ;
  logic enabled;
  logic edgeSet;

  assign corrIn  = rawIn ^ mode.activeLow;
  assign enabled = (mode.lvl != '0);
  assign edgeSet = enabled && mode.edgeMode && corrIn && !prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      prevQ <= corrIn;
      // A fresh edge wins over a clear in the same cycle
      pendQ <= edgeSet || (pendQ && !clrHit);
    end
  end

  assign reqOut = enabled && (mode.edgeMode ? pendQ : corrIn);
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic             reqVec [NUM_SRC],
  input  logic [LVL_W-1:0] lvlVec [NUM_SRC],
  output logic             anyReq,
  output logic [NUM_W-1:0] winIdx,
  output logic [LVL_W-1:0] winLvl
);
  // Scan from the top index down; ">=" lets a lower index take ties
  always_comb begin
    winLvl = '0;
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i] && (lvlVec[i] >= winLvl)) begin
        winLvl = lvlVec[i];
        winIdx = NUM_W'(i);
      end
    end
    anyReq = (winLvl != '0);
  end
endmodule

// File: rtl/pvic_datapath.sv
module pvic_datapath
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [VEC_W-1:0]   regWrData,
  input  logic [LVL_W-1:0]   cpuMask,
  output logic [VEC_W-1:0]   regRdData,
  output logic [VEC_W-1:0]   vecOut,
  output logic               cpuReq,
  output logic [LVL_W-1:0]   cpuLevel
);
  srcMode_t         modeQ  [NUM_SRC];
  logic             reqVec [NUM_SRC];
  logic [LVL_W-1:0] lvlVec [NUM_SRC];
  logic [NUM_W-1:0] clrNum;
  logic             anyReq;
  logic [NUM_W-1:0] winIdx;
  logic [LVL_W-1:0] winLvl;
  logic [VEC_W-1:0] vecQ;
  logic [LVL_W-1:0] lvlQ;
  logic             reqQ;

  assign clrNum = regWrData[VEC_W-1:VEC_LSB];

  // Mode words
  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(NUM_SRC); i++) begin
      if (!rstN)
        modeQ[i] <= '0;
      else if (strb.modeWr && (int'(regAddr) == i))
        modeQ[i] <= srcMode_t'(regWrData[MODE_W-1:0]);
    end
  end

  // Per-source detection
  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_src
    logic clrHit;
    assign clrHit    = strb.clrWr && (clrNum == NUM_W'(g));
    assign lvlVec[g] = modeQ[g].lvl;

    pvic_srcdet det_i (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (irqIn[g]),
      .mode   (modeQ[g]),
      .clrHit (clrHit),
      .reqOut (reqVec[g])
    );
  end

  pvic_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
    .reqVec (reqVec),
    .lvlVec (lvlVec),
    .anyReq (anyReq),
    .winIdx (winIdx),
    .winLvl (winLvl)
  );

  // Registered processor-facing outputs and vector register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ <= '0;
      lvlQ <= '0;
      reqQ <= 1'b0;
    end else begin
      lvlQ <= winLvl;
      reqQ <= anyReq && (winLvl > cpuMask);
      if (!strb.vecHold)
        vecQ <= anyReq ? {winIdx, {VEC_LSB{1'b0}}} : '0;
    end
  end

  // Read mux
  always_comb begin
    regRdData = '0;
    if (regAddr == VEC_ADDR) begin
      regRdData = vecQ;
    end else begin
      for (int i = 0; i < int'(NUM_SRC); i++) begin
        if (int'(regAddr) == i)
          regRdData = {{(VEC_W-MODE_W){1'b0}}, modeQ[i]};
      end
    end
  end

  assign vecOut   = vecQ;
  assign cpuReq   = reqQ;
  assign cpuLevel = lvlQ;
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [VEC_W-1:0]   regWrData,
  output logic [VEC_W-1:0]   regRdData,
  input  logic               cpuAck,
  input  logic [LVL_W-1:0]   cpuMask,
  output logic               cpuReq,
  output logic [LVL_W-1:0]   cpuLevel
);
  ctrlStrb_t        strb;
  logic             frozenW;
  logic             vecHoldW;
  logic [VEC_W-1:0] vecW;

  pvic_ctrl #(.NUM_SRC(NUM_SRC)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .cpuAck  (cpuAck),
    .strb    (strb),
    .frozen  (frozenW)
  );

  pvic_datapath #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .irqIn     (irqIn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .cpuMask   (cpuMask),
    .regRdData (regRdData),
    .vecOut    (vecW),
    .cpuReq    (cpuReq),
    .cpuLevel  (cpuLevel)
  );

  assign vecHoldW = strb.vecHold;
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker
  import pvic_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cpuAck,
  input logic             cpuReq,
  input logic [LVL_W-1:0] cpuLevel,
  input logic [LVL_W-1:0] cpuMask,
  input logic             vecHold,
  input logic             frozen,
  input logic [VEC_W-1:0] vecQ
);
  // R8: a raised request always sits above the mask it was judged against
  a_r8_req_above_mask: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (cpuLevel > $past(cpuMask)));

  // R1: a request never goes out with level zero
  a_r1_req_has_level: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (cpuLevel != '0));

  // R9: while held, the vector register keeps its value
  a_r9_hold_keeps_vec: assert property (@(posedge clk) disable iff (!rstN)
    vecHold |=> $stable(vecQ));

  // R9: an acknowledge leaves the control in the frozen state
  a_r9_ack_freezes: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |=> frozen);
endmodule

bind prio_vec_intc pvic_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cpuAck   (cpuAck),
  .cpuReq   (cpuReq),
  .cpuLevel (cpuLevel),
  .cpuMask  (cpuMask),
  .vecHold  (vecHoldW),
  .frozen   (frozenW),
  .vecQ     (vecW)
);

// File: tb/prio_vec_intc_tb_top.sv
module prio_vec_intc_tb_top;
  localparam int NSRC = 64;
  localparam logic [7:0] VADDR = 8'hFE;
  localparam logic [7:0] CADDR = 8'hFF;

  typedef struct {
    string      tag;
    logic [9:0] vec;
    logic [2:0] lvl;
    logic       req;
  } sbItem_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] irqIn = '0;
  logic            regWrEn = 1'b0;
  logic            regRdEn = 1'b0;
  logic [7:0]      regAddr = VADDR;
  logic [9:0]      regWrData = '0;
  logic [9:0]      regRdData;
  logic            cpuAck = 1'b0;
  logic [2:0]      cpuMask = '0;
  logic            cpuReq;
  logic [2:0]      cpuLevel;

  int testCnt = 0;
  int failCnt = 0;
  sbItem_t sbQ[$];
  event sampleEv;

  always #4 clk = ~clk;

  prio_vec_intc #(.NUM_SRC(NSRC)) dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cpuAck(cpuAck), .cpuMask(cpuMask),
    .cpuReq(cpuReq), .cpuLevel(cpuLevel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expectations and compares against the ports
  initial begin
    sbItem_t it;
    forever begin
      @(sampleEv);
      while (sbQ.size() > 0) begin
        it = sbQ.pop_front();
        chk({it.tag, " vector"}, int'(regRdData), int'(it.vec));
        chk({it.tag, " level"},  int'(cpuLevel),  int'(it.lvl));
        chk({it.tag, " req"},    int'(cpuReq),    int'(it.req));
      end
    end
  end

  // Driver side: let outputs settle, then queue the expectation
  task automatic expectOut(input string tag, input logic [9:0] v,
                           input logic [2:0] l, input logic r);
    sbItem_t it;
    repeat (3) @(posedge clk);
    #2;
    it.tag = tag; it.vec = v; it.lvl = l; it.req = r;
    sbQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  task automatic writeMode(input int src, input int lvl, input bit low, input bit edg);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'(src);
    regWrData = 10'({edg, low, 3'(lvl)});
    @(negedge clk);
    regWrEn = 1'b0; regAddr = VADDR;
  endtask

  task automatic writeClr(input int num);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = CADDR; regWrData = 10'(num << 4);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = VADDR;
  endtask

  task automatic pulseIrq(input int idx);
    @(negedge clk); irqIn[idx] = 1'b1;
    @(negedge clk); irqIn[idx] = 1'b0;
  endtask

  task automatic readMode(input string tag, input int src, input int exp);
    @(negedge clk); regAddr = 8'(src);
    #1 chk(tag, int'(regRdData), exp);
    @(negedge clk); regAddr = VADDR;
  endtask

  initial begin
    #1_000_000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    expectOut("R1 reset", 10'h000, 3'd0, 1'b0);
    readMode("R1 reset mode word", 5, 0);

    @(negedge clk) irqIn[3] = 1'b1;
    expectOut("R1 level zero ignored", 10'h000, 3'd0, 1'b0);

    writeMode(3, 4, 0, 0);
    expectOut("R6 level source 3", 10'h030, 3'd4, 1'b1);

    @(negedge clk) irqIn[10] = 1'b1;
    writeMode(10, 6, 0, 0);
    expectOut("R2 higher level wins", 10'h0A0, 3'd6, 1'b1);

    @(negedge clk) irqIn[7] = 1'b1;
    writeMode(7, 6, 0, 0);
    expectOut("R3 tie lowest number", 10'h070, 3'd6, 1'b1);

    @(negedge clk) cpuMask = 3'd6;
    expectOut("R8 mask equal blocks", 10'h070, 3'd6, 1'b0);
    @(negedge clk) cpuMask = 3'd5;
    expectOut("R8 mask below passes", 10'h070, 3'd6, 1'b1);
    @(negedge clk) cpuMask = 3'd0;

    @(negedge clk) begin irqIn[7] = 1'b0; irqIn[10] = 1'b0; end
    expectOut("R6 not latched", 10'h030, 3'd4, 1'b1);
    @(negedge clk) irqIn[3] = 1'b0;
    expectOut("R7 idle vector zero", 10'h000, 3'd0, 1'b0);

    writeMode(54, 5, 0, 1);
    pulseIrq(54);
    expectOut("R5 R7 edge held 0x360", 10'h360, 3'd5, 1'b1);
    writeClr(20);
    expectOut("R5 other clear ignored", 10'h360, 3'd5, 1'b1);
    writeClr(54);
    expectOut("R5 clear retires", 10'h000, 3'd0, 1'b0);

    @(negedge clk) irqIn[40] = 1'b1;
    writeMode(40, 3, 1, 0);
    expectOut("R4 low idle at one", 10'h000, 3'd0, 1'b0);
    @(negedge clk) irqIn[40] = 1'b0;
    expectOut("R4 low active at zero", 10'h280, 3'd3, 1'b1);
    @(negedge clk) irqIn[40] = 1'b1;
    expectOut("R4 low released", 10'h000, 3'd0, 1'b0);

    // R10: clear write and fresh edge in one cycle
    pulseIrq(54);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = CADDR; regWrData = 10'(54 << 4); irqIn[54] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = VADDR;
    expectOut("R10 edge beats clear", 10'h360, 3'd5, 1'b1);
    writeClr(54);
    expectOut("R10 steady input clears", 10'h000, 3'd0, 1'b0);
    @(negedge clk) irqIn[54] = 1'b0;

    // R9: freeze across a higher-priority arrival
    pulseIrq(54);
    expectOut("R9 before ack", 10'h360, 3'd5, 1'b1);
    writeMode(63, 7, 0, 1);
    @(negedge clk) cpuAck = 1'b1;
    @(negedge clk) cpuAck = 1'b0;
    pulseIrq(63);
    expectOut("R9 vector frozen", 10'h360, 3'd7, 1'b1);
    @(negedge clk) regRdEn = 1'b1;
    @(negedge clk) regRdEn = 1'b0;
    expectOut("R9 read releases", 10'h3F0, 3'd7, 1'b1);
    readMode("R11 mode readback 63", 63, 'h17);
    writeClr(63);
    expectOut("R5 back to 54", 10'h360, 3'd5, 1'b1);
    writeClr(54);
    expectOut("R5 all cleared", 10'h000, 3'd0, 1'b0);

    pulseIrq(54);
    writeMode(54, 0, 0, 1);
    expectOut("R1 level zero disables held", 10'h000, 3'd0, 1'b0);
    readMode("R11 mode readback 40", 40, 'h0B);

    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule